// File: doc/BRIEF.md
# Switch Input and Seven-Segment Output Port

This block is a peripheral in the I/O space of a 16-bit processor bus. It has one port address and two functions. A read cycle to that address places the state of eight switches on the low data lane. A write cycle to the same address loads a byte into an output register, and that register drives a seven-segment display.

A port cycle is recognised only when the memory/IO select input is low and the 16-bit I/O address matches the configured port address. A parameter picks between two decoders. The full decoder compares all sixteen address bits. The cheaper partial decoder compares only address bits 3..0, so the port then answers at many aliased addresses.

The read path models a tri-state buffer as a data value plus an enable. Bit 7 of the output register selects what the display shows. With bit 7 clear, bits 6..0 go straight to the segments. With bit 7 set, a built-in encoder shows the number of the lowest closed switch, so the display works without any software conversion.

Top module: `swd_port`

## Requirements
- R1: A port cycle is recognised only when `mem_io_sel` is 0 and the address matches the port address (default 16'h0740). When `mem_io_sel` is 1, neither reads nor writes have any effect.
- R2: In a cycle where `rd_stb` is 1 and the port is selected, `rdata_oe` is 1 and `rdata` equals `switches` in that same cycle. Bit i of `rdata` is switch i+1, and a closed switch reads 1.
- R3: In every other cycle, `rdata_oe` is 0 and `rdata` is 8'h00. This is the released bus.
- R4: If `wr_stb` is 1 and the port is selected at a rising clock edge, the output register takes `wdata` at that edge. It keeps that value until the next selected write.
- R5: A write whose address does not match the decoder leaves the output register, and so the display, unchanged.
- R6: While `rst_n` is low, the output register clears to 8'h00, which leaves all segments off.
- R7: When register bit 7 is 0, `seg` equals register bits 6..0. Segments are active high, with `seg[0]`=a through `seg[6]`=g.
- R8: When register bit 7 is 1 and at least one switch is closed, `seg` shows the number n (1..8) of the lowest closed switch. The codes are: 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F. The display follows the switches in the same cycle.
- R9: When register bit 7 is 1 and no switch is closed, `seg` is 7'h00 (blank).
- R10: With `FULL_DECODE`=0, only address bits 3..0 are compared. For example, 16'h1230 and 16'h0750 both select the port, and 16'h0741 does not.
- R11: A cycle with both `rd_stb` and `wr_stb` at the selected address does both actions. The read returns the switches, and the write loads `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | I/O address of the current cycle |
| mem_io_sel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_stb | input | 1 | Read strobe, one cycle long |
| wr_stb | input | 1 | Write strobe, one cycle long |
| wdata | input | 8 | Low byte of the write data bus |
| switches | input | 8 | Switch levels, 1 = closed |
| rdata | output | 8 | Read data, 0 when the bus is released |
| rdata_oe | output | 1 | Drive enable of the read buffer |
| seg | output | 7 | Segments a..g, active high |

## Verification
A read and a write can hit the port in the same cycle. One path is combinational on the data lane and the other is registered in the output register. The bench drives both strobes together at the port address, with a switch pattern that differs from the written byte. It then expects the switch pattern on `rdata` and the written byte on `seg` one edge later, so a swap or a loss of either action shows up. A second instance with partial decoding receives the same stimulus, so the aliasing addresses are judged against the full decoder's rejections.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int SW_N  = 8;
  localparam int SEG_W = 7;

  // Returns 1..8 for the lowest set bit, 0 when no bit is set.
  function automatic logic [3:0] lowest_closed(input logic [SW_N-1:0] sw);
    logic [3:0] n;
    n = 4'd0;
    for (int k = SW_N - 1; k >= 0; k--) begin
      if (sw[k]) n = 4'(k + 1);
    end
    return n;
  endfunction

  // Segment pattern for a digit, bit0 = a ... bit6 = g, active high.
  function automatic logic [SEG_W-1:0] digit_seg(input logic [3:0] d);
    logic [SEG_W-1:0] s;
    unique case (d)
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/swd_decode.sv
module swd_decode #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] PORT_ADDR   = 16'h0740,
  parameter bit          FULL_DECODE = 1'b1,
  parameter int          LITE_BITS   = 4
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              mem_io_sel,
  output logic              hit
);
  logic addr_match;
  generate
    if (FULL_DECODE) begin : g_full
      assign addr_match = (io_addr == PORT_ADDR[ADDR_W-1:0]);
    end else begin : g_lite
      assign addr_match = (io_addr[LITE_BITS-1:0] == PORT_ADDR[LITE_BITS-1:0]);
    end
  endgenerate
  assign hit = addr_match && !mem_io_sel;
endmodule

// File: rtl/swd_latch.sv
module swd_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/swd_display.sv
module swd_display
  import swd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ctl,
  input  logic [SW_N-1:0]   switches,
  output logic [SEG_W-1:0]  seg
);
  localparam int AUTO_BIT = DATA_W - 1;
  logic [3:0] key_num;
  assign key_num = lowest_closed(switches);
  always_comb begin
    if (ctl[AUTO_BIT]) seg = digit_seg(key_num);
    else               seg = ctl[SEG_W-1:0];
  end
endmodule

// File: rtl/swd_port.sv
module swd_port
  import swd_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] PORT_ADDR   = 16'h0740,
  parameter bit          FULL_DECODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              mem_io_sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SW_N-1:0]   switches,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic [SEG_W-1:0]  seg
);
  logic              port_hit;
  logic              rd_hit;
  logic              wr_hit;
  logic [DATA_W-1:0] latch_q;

  swd_decode #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .FULL_DECODE(FULL_DECODE), .LITE_BITS(4)
  ) u_dec (
    .io_addr(io_addr), .mem_io_sel(mem_io_sel), .hit(port_hit)
  );

  assign rd_hit = port_hit && rd_stb;
  assign wr_hit = port_hit && wr_stb;

  assign rdata_oe = rd_hit;
  assign rdata    = rd_hit ? DATA_W'(switches) : '0;

  swd_latch #(.DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .d(wdata), .q(latch_q)
  );

  swd_display #(.DATA_W(DATA_W)) u_disp (
    .ctl(latch_q), .switches(switches), .seg(seg)
  );
endmodule

// File: rtl/swd_port_chk.sv
module swd_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_io_sel,
  input logic          rd_stb,
  input logic [DW-1:0] wdata,
  input logic [7:0]    switches,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic [6:0]    seg,
  input logic          port_hit,
  input logic          wr_hit,
  input logic [DW-1:0] latch_q
);
  a_r1_io_only: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |-> !mem_io_sel);
  a_r2_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && rd_stb) |-> (rdata_oe && rdata == DW'(switches)));
  a_r3_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (latch_q == $past(wdata)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(latch_q));
  a_r7_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q[DW-1] |-> (seg == latch_q[6:0]));
  a_r8_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q[DW-1] && switches != 8'h00) |-> (seg != 7'h00));
  a_r9_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q[DW-1] && switches == 8'h00) |-> (seg == 7'h00));
endmodule

bind swd_port swd_port_chk #(.DW(DATA_W)) u_chk (.*);

// File: tb/test_swd_port.sv
module test_swd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        mem_io_sel = 1'b1;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  switches = 8'h00;
  logic [7:0]  rdata_f, rdata_l;
  logic        oe_f, oe_l;
  logic [6:0]  seg_f, seg_l;

  always #2 clk = ~clk;

  swd_port i_swd_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .mem_io_sel(mem_io_sel),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .switches(switches),
    .rdata(rdata_f), .rdata_oe(oe_f), .seg(seg_f));

  swd_port #(.FULL_DECODE(1'b0)) i_swd_port_lite (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .mem_io_sel(mem_io_sel),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .switches(switches),
    .rdata(rdata_l), .rdata_oe(oe_l), .seg(seg_l));

  typedef struct {
    string      tag;
    logic       oe_f, oe_l;
    logic [7:0] rd_f, rd_l;
    logic [6:0] seg_f, seg_l;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  logic [7:0] mlat_f = 8'h00;
  logic [7:0] mlat_l = 8'h00;

  function automatic logic [6:0] model_seg(input logic [7:0] lat, input logic [7:0] s);
    logic [6:0] code [0:8];
    code = '{7'h00, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F};
    if (!lat[7]) return lat[6:0];
    for (int k = 0; k < 8; k++) if (s[k]) return code[k + 1];
    return 7'h00;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic [15:0] a, input logic m, input logic r,
                    input logic w, input logic [7:0] d, input logic [7:0] s);
    exp_t e;
    logic sf, sl;
    @(negedge clk);
    io_addr = a; mem_io_sel = m; rd_stb = r; wr_stb = w; wdata = d; switches = s;
    sf = !m && (a == 16'h0740);
    sl = !m && (a[3:0] == 4'h0);
    if (sf && w) mlat_f = d;
    if (sl && w) mlat_l = d;
    e.tag = tag;
    e.oe_f = sf && r;  e.rd_f = (sf && r) ? s : 8'h00;
    e.oe_l = sl && r;  e.rd_l = (sl && r) ? s : 8'h00;
    e.seg_f = model_seg(mlat_f, s);
    e.seg_l = model_seg(mlat_l, s);
    q.push_back(e);
  endtask

  // monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "oe_full",   {7'd0, oe_f},  {7'd0, e.oe_f});
        chk(e.tag, "rdata_full", rdata_f,      e.rd_f);
        chk(e.tag, "seg_full",  {1'b0, seg_f}, {1'b0, e.seg_f});
        chk(e.tag, "oe_lite",   {7'd0, oe_l},  {7'd0, e.oe_l});
        chk(e.tag, "rdata_lite", rdata_l,      e.rd_l);
        chk(e.tag, "seg_lite",  {1'b0, seg_l}, {1'b0, e.seg_l});
      end
    end
  end

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    op("R6 reset blank, R3 idle", 16'h0000, 1'b1, 0, 0, 8'h00, 8'h00);
    op("R2 read switches", 16'h0740, 1'b0, 1, 0, 8'h00, 8'hA5);
    op("R1 memory cycle ignored", 16'h0740, 1'b1, 1, 1, 8'h7F, 8'h3C);
    op("R3 released after read", 16'h0740, 1'b0, 0, 0, 8'h00, 8'hFF);
    op("R1 wrong address read", 16'h0741, 1'b0, 1, 0, 8'h00, 8'h81);
    op("R10 alias read 1230", 16'h1230, 1'b0, 1, 0, 8'h00, 8'h5A);
    op("R4 R7 write raw", 16'h0740, 1'b0, 0, 1, 8'h5B, 8'h00);
    op("R4 hold", 16'h0000, 1'b0, 0, 0, 8'h00, 8'h00);
    op("R5 write memory cycle", 16'h0740, 1'b1, 0, 1, 8'h11, 8'h00);
    op("R5 R10 write 0750", 16'h0750, 1'b0, 0, 1, 8'h22, 8'h00);
    op("R5 write 0741", 16'h0741, 1'b0, 0, 1, 8'h33, 8'h00);
    op("R9 auto blank", 16'h0740, 1'b0, 0, 1, 8'h80, 8'h00);
    for (int k = 0; k < 8; k++)
      op("R8 single switch", 16'h0000, 1'b1, 0, 0, 8'h00, 8'(1 << k));
    op("R8 lowest wins 0C", 16'h0000, 1'b1, 0, 0, 8'h00, 8'h0C);
    op("R8 lowest wins F0", 16'h0000, 1'b1, 0, 0, 8'h00, 8'hF0);
    op("R8 all closed", 16'h0000, 1'b1, 0, 0, 8'h00, 8'hFF);
    op("R9 reopen blank", 16'h0000, 1'b1, 0, 0, 8'h00, 8'h00);
    op("R11 read and write", 16'h0740, 1'b0, 1, 1, 8'h3F, 8'h42);
    op("R11 read and write auto", 16'h0740, 1'b0, 1, 1, 8'h80, 8'h24);
    op("R7 raw after auto", 16'h0740, 1'b0, 0, 1, 8'h71, 8'h08);
    op("R3 final idle", 16'h0000, 1'b1, 0, 0, 8'h00, 8'h08);
    repeat (4) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule